// File: doc/BRIEF.md
# Tone-Disable Event Interrupt Queue

This block gathers tone-disable status changes from a set of voice channels and hands them to a host processor. Each channel has one status line. Every change on that line is a detect event (the line goes high) or a release event (the line goes low). Unless the event is masked for its channel, the event is recorded as pending and then written into a first-in first-out queue as the channel number.

The host sees one active-low interrupt line and a small register space. When the interrupt line falls, the host reads the queue register. That read removes the oldest channel number, and the host then reads that channel's status register to learn whether tone disable is now present. Every read of the queue register forces the interrupt line high for a short guaranteed gap. If more entries remain after the gap, the line falls again, once per remaining entry. A global mask holds the line high, but events keep queueing while it is set. When the queue is full, further events are lost and a sticky overflow flag records the loss.

Registers are addressed as `{page[1:0], index[CH_W-1:0]}`.
- Page 0 holds three registers:
  - Index 0 is the queue register.
  - Index 1 is the global control register.
  - Index 2 is the overflow register.
- Page 1 holds the per-channel control registers, indexed by channel.
- Page 2 holds the per-channel status registers, indexed by channel.

Top module: `tone_evt_irq`

## Requirements
- R1: After reset, `irq_n_o` is 1, `reg_rdata_o` is 0, the queue is empty, and all mask bits and the overflow flag are 0.
- R2: When an unmasked channel `c` goes from 0 to 1 (detect) or from 1 to 0 (release), the event is queued and a later queue read returns `c`.
- R3: Per-channel control bit 0 masks detect events and bit 1 masks release events. A masked event is never queued.
- R4: Pending events enter the queue at most one per clock, in a fixed order:
  - the lowest channel goes first;
  - within one channel, a detect goes ahead of a release;
  - queue reads return entries in the order they were written.
- R5: A queue read returns `{1'b0, zeros, channel}` and removes that entry. A queue read on an empty queue returns 8'h80 and leaves the queue unchanged.
- R6: In the cycle after a clock edge at which the queue is non-empty, global control bit 0 is clear, and no hold-off is running, `irq_n_o` is 0.
- R7: A queue read drives `irq_n_o` high for at least HOLD cycles (default 2). After that gap the line falls again if entries remain.
- R8: While global control bit 0 is set, `irq_n_o` stays high, and events are still queued.
- R9: An event that arrives while the queue holds DEPTH entries is dropped and sets overflow register bit 0. Writing 1 to that bit clears it, but a drop in the same cycle wins over the clear.
- R10: Status register bit 0 of channel `c` reads that channel's tone-disable level as sampled at the previous clock edge.
- R11: The control registers read back the values last written to them. Writes to the queue register, the overflow bits other than bit 0, and unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_dis_i | input | NUM_CH | Per-channel tone-disable status levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | CH_W+2 | Register address: `{page, index}` |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The following faults show up at the ports:
- A lost or duplicated pending bit shows up as a wrong channel number or a missing entry. It appears at the queue read that would return that entry, which can come only a few reads later.
- A wrong entry count in the queue shows up quickly in `irq_n_o`. The line either falls on an empty queue or stays high over entries that are still pending, within one cycle after the gap following a read.
- A wrong hold-off counter shows up as a high gap of the wrong length on the cycle right after a read.
- A mis-set overflow flag shows up only when the overflow register is read.

This is why the bench compares `irq_n_o` and `reg_rdata_o` with its model on every clock.

// File: rtl/tdq_pkg.sv
package tdq_pkg;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] EMPTY_CODE = 8'h80;

  typedef enum logic [1:0] {
    PG_GLOBAL = 2'd0,
    PG_CHCTL  = 2'd1,
    PG_CHSTAT = 2'd2,
    PG_NONE   = 2'd3
  } page_e;

  localparam int IDX_QUEUE = 0;
  localparam int IDX_GCTL  = 1;
  localparam int IDX_OVF   = 2;
endpackage

// File: rtl/tdq_edge_arb.sv
module tdq_edge_arb #(
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int NREQ = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] tone_i,
  input  logic [NUM_CH-1:0] mask_det_i,
  input  logic [NUM_CH-1:0] mask_rel_i,
  output logic [NUM_CH-1:0] td_q_o,
  output logic              evt_valid_o,
  output logic [CH_W-1:0]   evt_ch_o
);
  logic [NUM_CH-1:0] td_q;
  logic [NREQ-1:0]   req_q, set_v, clr_v;

  // request 2c is channel c detect, 2c+1 its release
  for (genvar c = 0; c < NUM_CH; c++) begin : g_edge
    assign set_v[2*c]   =  tone_i[c] & ~td_q[c] & ~mask_det_i[c];
    assign set_v[2*c+1] = ~tone_i[c] &  td_q[c] & ~mask_rel_i[c];
  end

  always_comb begin
    clr_v       = '0;
    evt_valid_o = 1'b0;
    evt_ch_o    = '0;
    for (int k = 0; k < NREQ; k++) begin
      if (req_q[k] && !evt_valid_o) begin
        evt_valid_o = 1'b1;
        clr_v[k]    = 1'b1;
        evt_ch_o    = CH_W'(k / 2);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      td_q  <= '0;
      req_q <= '0;
    end else begin
      td_q  <= tone_i;
      req_q <= (req_q & ~clr_v) | set_v;
    end
  end

  assign td_q_o = td_q;

  // R2
  evt_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_v) |=> (|req_q));
endmodule

// File: rtl/tdq_fifo.sv
module tdq_fifo #(
  parameter int DEPTH = 32,
  parameter int W = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] pop_data_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty_o = (count == '0);
  assign full_o  = (count == CW'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data_i;
    if (do_pop)  pop_data_o <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && empty_o) |=> empty_o);
  // R9
  full_push_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && full_o) |=> full_o);
endmodule

// File: rtl/tdq_irq.sv
module tdq_irq #(
  parameter int HOLD = 2,
  localparam int HW = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic q_read_i,
  input  logic pending_i,
  input  logic gmask_i,
  output logic irq_n_o
);
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      irq_n_o <= 1'b1;
    end else if (q_read_i) begin
      hold_q  <= HW'(HOLD - 1);
      irq_n_o <= 1'b1;
    end else if (hold_q != '0) begin
      hold_q  <= hold_q - 1'b1;
      irq_n_o <= 1'b1;
    end else begin
      irq_n_o <= ~(pending_i & ~gmask_i);
    end
  end

  // R7
  read_gap_chk: assert property (@(posedge clk) disable iff (rst)
    q_read_i |=> irq_n_o);
endmodule

// File: rtl/tone_evt_irq.sv
module tone_evt_irq #(
  parameter int NUM_CH = 16,
  parameter int DEPTH = 32,
  parameter int HOLD = 2,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CH-1:0]         tone_dis_i,
  input  logic                      reg_wr_i,
  input  logic                      reg_rd_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic [tdq_pkg::DATA_W-1:0] reg_wdata_i,
  output logic [tdq_pkg::DATA_W-1:0] reg_rdata_o,
  output logic                      irq_n_o
);
  import tdq_pkg::*;

  logic [NUM_CH-1:0] mdet_q, mrel_q, td_q;
  logic              gmask_q, ovf_q;
  logic [DATA_W-1:0] rd_q;
  logic              q_hit_q;
  logic              evt_valid, fifo_empty, fifo_full;
  logic [CH_W-1:0]   evt_ch, fifo_dout;
  page_e             page;
  logic [CH_W-1:0]   idx;
  logic              is_queue, q_read, is_gctl, is_ovf, ch_ok;
  logic              wdata_unused;

  assign page     = page_e'(reg_addr_i[ADDR_W-1 -: 2]);
  assign idx      = reg_addr_i[CH_W-1:0];
  assign ch_ok    = (32'(idx) < NUM_CH);
  assign is_queue = (page == PG_GLOBAL) && (32'(idx) == IDX_QUEUE);
  assign is_gctl  = (page == PG_GLOBAL) && (32'(idx) == IDX_GCTL);
  assign is_ovf   = (page == PG_GLOBAL) && (32'(idx) == IDX_OVF);
  assign q_read   = reg_rd_i & is_queue;
  assign wdata_unused = ^reg_wdata_i[DATA_W-1:2];

  tdq_edge_arb #(.NUM_CH(NUM_CH)) u_edge (
    .clk(clk), .rst(rst), .tone_i(tone_dis_i),
    .mask_det_i(mdet_q), .mask_rel_i(mrel_q), .td_q_o(td_q),
    .evt_valid_o(evt_valid), .evt_ch_o(evt_ch)
  );

  tdq_fifo #(.DEPTH(DEPTH), .W(CH_W)) u_fifo (
    .clk(clk), .rst(rst), .push_i(evt_valid), .push_data_i(evt_ch),
    .pop_i(q_read), .pop_data_o(fifo_dout),
    .empty_o(fifo_empty), .full_o(fifo_full)
  );

  tdq_irq #(.HOLD(HOLD)) u_irq (
    .clk(clk), .rst(rst), .q_read_i(q_read), .pending_i(~fifo_empty),
    .gmask_i(gmask_q), .irq_n_o(irq_n_o)
  );

  // control and overflow registers
  always_ff @(posedge clk) begin
    if (rst) begin
      gmask_q <= 1'b0;
      ovf_q   <= 1'b0;
      mdet_q  <= '0;
      mrel_q  <= '0;
    end else begin
      ovf_q <= (ovf_q & ~(reg_wr_i & is_ovf & reg_wdata_i[0]))
             | (evt_valid & fifo_full);
      if (reg_wr_i && is_gctl) gmask_q <= reg_wdata_i[0];
      if (reg_wr_i && page == PG_CHCTL && ch_ok) begin
        mdet_q[idx] <= reg_wdata_i[0];
        mrel_q[idx] <= reg_wdata_i[1];
      end
    end
  end

  // read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= '0;
      q_hit_q <= 1'b0;
    end else if (reg_rd_i) begin
      q_hit_q <= is_queue & ~fifo_empty;
      rd_q    <= '0;
      case (page)
        PG_GLOBAL: begin
          if (is_queue)     rd_q <= EMPTY_CODE;
          else if (is_gctl) rd_q <= DATA_W'(gmask_q);
          else if (is_ovf)  rd_q <= DATA_W'(ovf_q);
        end
        PG_CHCTL:  if (ch_ok) rd_q <= DATA_W'({mrel_q[idx], mdet_q[idx]});
        PG_CHSTAT: if (ch_ok) rd_q <= DATA_W'(td_q[idx]);
        default:   rd_q <= '0;
      endcase
    end
  end

  assign reg_rdata_o = q_hit_q ? DATA_W'(fifo_dout) : rd_q;

  // R6
  irq_pending_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n_o |-> !fifo_empty);
  // R8
  gmask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    gmask_q |=> irq_n_o);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !reg_wr_i) |=> ovf_q);
endmodule

// File: tb/test_tone_evt_irq.sv
module test_tone_evt_irq;
  localparam int N = 16;
  localparam int DEPTH = 32;
  localparam int HOLD = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] tone = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq_n;

  int checks = 0, fails = 0, cyc = 0;

  tone_evt_irq i_tone_evt_irq (
    .clk(clk), .rst(rst), .tone_dis_i(tone), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_n_o(irq_n)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int   mq[$];
  bit   m_prev[N], m_pd[N], m_pr[N], m_mdet[N], m_mrel[N];
  bit   m_gm, m_ovf, m_irq;
  int   m_hold;
  logic [7:0] m_rdata;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mq.delete();
      for (int c = 0; c < N; c++) begin
        m_prev[c] = 0; m_pd[c] = 0; m_pr[c] = 0; m_mdet[c] = 0; m_mrel[c] = 0;
      end
      m_gm = 0; m_ovf = 0; m_irq = 1; m_hold = 0; m_rdata = 8'h00;
    end else begin
      int pre_cnt, g, pg, ix;
      bit pre_gm, pop;
      pre_cnt = mq.size();
      pre_gm  = m_gm;
      pg = int'(addr[5:4]);
      ix = int'(addr[3:0]);
      pop = rd && pg == 0 && ix == 0;
      g = -1;
      for (int k = 0; k < 2 * N; k++)
        if (g < 0 && ((k % 2 == 0) ? m_pd[k/2] : m_pr[k/2])) g = k;
      if (rd) begin
        m_rdata = 8'h00;
        if (pg == 0 && ix == 0) m_rdata = (pre_cnt > 0) ? 8'(mq[0]) : 8'h80;
        else if (pg == 0 && ix == 1) m_rdata = {7'd0, m_gm};
        else if (pg == 0 && ix == 2) m_rdata = {7'd0, m_ovf};
        else if (pg == 1) m_rdata = {6'd0, m_mrel[ix], m_mdet[ix]};
        else if (pg == 2) m_rdata = {7'd0, m_prev[ix]};
      end
      if (pop && pre_cnt > 0) void'(mq.pop_front());
      if (wr && pg == 0 && ix == 2 && wdata[0]) m_ovf = 0;
      if (g >= 0) begin
        if (pre_cnt < DEPTH) mq.push_back(g / 2);
        else m_ovf = 1;
        if (g % 2 == 0) m_pd[g/2] = 0; else m_pr[g/2] = 0;
      end
      for (int c = 0; c < N; c++) begin
        if (tone[c] && !m_prev[c] && !m_mdet[c]) m_pd[c] = 1;
        if (!tone[c] && m_prev[c] && !m_mrel[c]) m_pr[c] = 1;
      end
      if (pop) begin m_irq = 1; m_hold = HOLD - 1; end
      else if (m_hold > 0) begin m_hold--; m_irq = 1; end
      else m_irq = !(pre_cnt > 0 && !pre_gm);
      if (wr && pg == 0 && ix == 1) m_gm = wdata[0];
      if (wr && pg == 1) begin m_mdet[ix] = wdata[0]; m_mrel[ix] = wdata[1]; end
      for (int c = 0; c < N; c++) m_prev[c] = tone[c];
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // every-cycle comparison against the model (R6, R7, R5)
  always @(negedge clk) begin
    if (!rst) begin
      check(irq_n === m_irq, "R6 irq_n vs model", int'(irq_n), int'(m_irq));
      check(rdata === m_rdata, "R5 rdata vs model", int'(rdata), int'(m_rdata));
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wreg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [7:0] v;
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(irq_n === 1'b1, "R1 irq_n after reset", int'(irq_n), 1);
    check(rdata === 8'h00, "R1 rdata after reset", int'(rdata), 0);
    rreg(6'h02, v); check(v === 8'h00, "R1 overflow clear", int'(v), 0);
    rreg(6'h13, v); check(v === 8'h00, "R1 masks clear", int'(v), 0);
    rreg(6'h00, v); check(v === 8'h80, "R5 empty read", int'(v), 'h80);

    // R2 detect and release of channel 3
    @(negedge clk); tone[3] = 1'b1;
    idle(4);
    check(irq_n === 1'b0, "R6 irq asserted", int'(irq_n), 0);
    rreg(6'h00, v); check(v === 8'h03, "R2 detect ch3", int'(v), 3);
    rreg(6'h23, v); check(v === 8'h01, "R10 status ch3 high", int'(v), 1);
    @(negedge clk); tone[3] = 1'b0;
    idle(4);
    rreg(6'h00, v); check(v === 8'h03, "R2 release ch3", int'(v), 3);
    rreg(6'h00, v); check(v === 8'h80, "R5 empty after drain", int'(v), 'h80);

    // R3 mask detect on ch5, release unmasked
    wreg(6'h15, 8'h01);
    rreg(6'h15, v); check(v === 8'h01, "R11 ctrl readback", int'(v), 1);
    @(negedge clk); tone[5] = 1'b1;
    idle(5);
    check(irq_n === 1'b1, "R3 masked detect no irq", int'(irq_n), 1);
    rreg(6'h00, v); check(v === 8'h80, "R3 masked detect not queued", int'(v), 'h80);
    @(negedge clk); tone[5] = 1'b0;
    idle(4);
    rreg(6'h00, v); check(v === 8'h05, "R3 release still queued", int'(v), 5);
    wreg(6'h15, 8'h02);
    @(negedge clk); tone[5] = 1'b1;
    idle(4);
    @(negedge clk); tone[5] = 1'b0;
    idle(4);
    rreg(6'h00, v); check(v === 8'h05, "R3 detect unmasked", int'(v), 5);
    rreg(6'h00, v); check(v === 8'h80, "R3 masked release dropped", int'(v), 'h80);
    wreg(6'h15, 8'h00);

    // R4 simultaneous events, ordering
    @(negedge clk); tone[9] = 1'b1; tone[2] = 1'b1; tone[7] = 1'b1;
    idle(6);
    // R7 gap after read
    rreg(6'h00, v); check(v === 8'h02, "R4 first lowest", int'(v), 2);
    check(irq_n === 1'b1, "R7 gap cycle 1", int'(irq_n), 1);
    @(negedge clk); check(irq_n === 1'b1, "R7 gap cycle 2", int'(irq_n), 1);
    @(negedge clk); check(irq_n === 1'b0, "R7 reassert", int'(irq_n), 0);
    rreg(6'h00, v); check(v === 8'h07, "R4 second", int'(v), 7);
    rreg(6'h00, v); check(v === 8'h09, "R4 third", int'(v), 9);
    @(negedge clk); tone[1] = 1'b1; tone[6] = 1'b1;
    @(negedge clk); tone[1] = 1'b0;
    idle(6);
    rreg(6'h00, v); check(v === 8'h01, "R4 ch1 detect", int'(v), 1);
    rreg(6'h00, v); check(v === 8'h01, "R4 ch1 release before ch6", int'(v), 1);
    rreg(6'h00, v); check(v === 8'h06, "R4 ch6 last", int'(v), 6);
    rreg(6'h00, v); check(v === 8'h80, "R5 empty", int'(v), 'h80);
    @(negedge clk); tone = '0;
    idle(6);
    for (int i = 0; i < 4; i++) rreg(6'h00, v);

    // R8 global mask
    wreg(6'h01, 8'h01);
    rreg(6'h01, v); check(v === 8'h01, "R11 gctl readback", int'(v), 1);
    @(negedge clk); tone[10] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); check(irq_n === 1'b1, "R8 masked irq high", int'(irq_n), 1);
    end
    wreg(6'h01, 8'h00);
    idle(2);
    check(irq_n === 1'b0, "R8 unmask asserts", int'(irq_n), 0);
    rreg(6'h00, v); check(v === 8'h0a, "R8 event kept", int'(v), 10);
    @(negedge clk); tone[10] = 1'b0;
    idle(4);
    rreg(6'h00, v);
    rreg(6'h00, v); check(v === 8'h80, "R5 empty again", int'(v), 'h80);

    // R9 overflow: 32 events fill the queue, a 33rd is dropped
    @(negedge clk); tone = '1;
    idle(20);
    @(negedge clk); tone = '0;
    idle(20);
    @(negedge clk); tone[0] = 1'b1;
    idle(5);
    rreg(6'h02, v); check(v === 8'h01, "R9 overflow set", int'(v), 1);
    wreg(6'h02, 8'h00);
    rreg(6'h02, v); check(v === 8'h01, "R11 zero write keeps flag", int'(v), 1);
    wreg(6'h02, 8'h01);
    rreg(6'h02, v); check(v === 8'h00, "R9 overflow cleared", int'(v), 0);
    for (int i = 0; i < 2 * N; i++) begin
      rreg(6'h00, v);
      check(v === 8'(i % N), "R9 retained entry", int'(v), i % N);
    end
    rreg(6'h00, v); check(v === 8'h80, "R9 dropped event absent", int'(v), 'h80);
    rreg(6'h20, v); check(v === 8'h01, "R10 status ch0", int'(v), 1);
    rreg(6'h21, v); check(v === 8'h00, "R10 status ch1", int'(v), 0);
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule